// File: doc/BRIEF.md
# Bit-serial command/status transceiver

This block is a serial master that trades one 32-bit command word for one 32-bit status word with an external controller. It uses three wires: a clock it drives, a data line it drives, and a data line it reads back. A single-cycle start request launches a full transaction. The transaction opens with a start condition, moves 32 data bits, and closes with a stop condition.

The command goes out most significant bit first. The reply is collected in the same bit order. When the stop condition is over, the block presents the collected word and pulses a done flag. The two top bits of that word are replaced by the page bits of the command that produced it. Every phase on the wires lasts a run-time programmable number of system clocks, so a slow controller on the far side can keep pace.

Top module: `cmdstat_serial_master`

## Requirements
- R1: While no transaction is running, the serial clock and the serial data output both sit high and busy is low. Straight after reset the status output reads zero.
- R2: A start pulse seen while idle is accepted on that clock edge. Busy is then high from the next cycle for exactly 131 phase lengths.
- R3: The start condition lasts two phases. In the first phase the data output is low while the clock stays high. In the second phase both lines are low.
- R4: Command bit 31 goes out first and bit 0 goes out last. Each bit takes four phases, with the clock low, high, low and low in turn. The data output holds the bit for all four phases.
- R5: The serial input passes through a two-flop synchronizer. It is sampled at the end of the bit's third phase, which is the low phase right after the high phase. The first bit sampled lands in status bit 31. The input must be steady from the start of the bit's first phase.
- R6: The stop condition lasts one phase, with the clock high and the data output low. After that both lines return to the idle level.
- R7: The reported status holds the 30 low captured bits in bits 29..0. Bits 31..30 carry command bits 31..30.
- R8: Done is high for exactly one cycle, in the first idle cycle after the stop phase. The status output takes its new value in that same cycle and does not change again until the next transaction completes.
- R9: A start pulse during a transaction is ignored. Changes to the command or phase-length inputs during a transaction have no effect, because both are captured at acceptance.
- R10: One phase lasts as many system clocks as the phase-length input gives. The value 0 counts as 1.
- R11: A synchronous active-low reset aborts any transaction. It returns the lines to idle and clears busy, done and status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| cmd_i | input | 32 | Command word, captured at acceptance |
| unit_i | input | 16 | Phase length in system clocks, captured at acceptance |
| busy_o | output | 1 | A transaction is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 32 | Last completed status word |
| ser_clk_o | output | 1 | Serial clock to the controller |
| ser_dout_o | output | 1 | Serial data to the controller |
| ser_din_i | input | 1 | Serial data from the controller |

## Verification
The bound checker watches several rules on every cycle:
- the lines rest high whenever busy is low;
- done is a lone pulse that follows busy;
- status never moves outside a done cycle;
- exactly 33 rising serial clock edges occur between acceptance and done;
- the page bits of the status match the command that was accepted.

Some behaviour only the bench scenarios can show, through its per-cycle waveform model:
- the exact phase widths, including the length of 0 treated as 1;
- MSB-first ordering and the bit-31-first capture of the reply;
- that a start pulse and input changes during a transaction have no effect;
- that a reset mid-transaction aborts it.

// File: rtl/cst_pkg.sv
// Shared types for the bit-serial command/status transceiver.
// Assumes: the phases listed here are the only ones the sequencer uses.
package cst_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_STA_A,
        PH_STA_B,
        PH_BIT_SET,
        PH_BIT_HI,
        PH_BIT_LO,
        PH_BIT_GAP,
        PH_STOP
    } phase_e;
endpackage

// File: rtl/cst_sync2.sv
// Multi-flop synchronizer for the serial input.
// Assumes: STAGES >= 2. The chain resets to 1, the idle level of the line.
module cst_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cst_phase_timer.sv
// Phase length timer: counts system clocks within the current phase and
// flags the last cycle. The length is captured when a transaction starts,
// and a value of 0 is promoted to 1.
// Assumes: run_i is high for every cycle of a transaction.
module cst_phase_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] unit_i,
    input  logic             run_i,
    output logic             phase_end_o
);
    logic [CNT_W-1:0] unit_q;
    logic [CNT_W-1:0] cnt_q;

    // Capture the phase length at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)      unit_q <= CNT_W'(1);
        else if (load_i) unit_q <= (unit_i == '0) ? CNT_W'(1) : unit_i;
    end

    // Count cycles within the phase and wrap at its end.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load_i || !run_i)     cnt_q <= '0;
        else if (phase_end_o)          cnt_q <= '0;
        else                           cnt_q <= cnt_q + CNT_W'(1);
    end

    assign phase_end_o = run_i && (cnt_q == unit_q - CNT_W'(1));
endmodule

// File: rtl/cst_sequencer.sv
// Transaction sequencer: walks start, 32 four-phase bits and stop.
// It produces the strobes that the data path uses.
// Assumes: phase_end_i pulses on the last cycle of each phase.
module cst_sequencer
    import cst_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  logic   phase_end_i,
    output phase_e phase_o,
    output logic   busy_o,
    output logic   accept_o,
    output logic   sample_o,
    output logic   advance_o,
    output logic   finish_o
);
    phase_e           phase_q, phase_d;
    logic [IDX_W-1:0] bit_idx_q;
    logic             last_bit;

    assign last_bit = (bit_idx_q == IDX_W'(WORD_W - 1));

    // Next-phase decision, taken only at the end of a phase.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:    if (start_i)     phase_d = PH_STA_A;
            PH_STA_A:   if (phase_end_i) phase_d = PH_STA_B;
            PH_STA_B:   if (phase_end_i) phase_d = PH_BIT_SET;
            PH_BIT_SET: if (phase_end_i) phase_d = PH_BIT_HI;
            PH_BIT_HI:  if (phase_end_i) phase_d = PH_BIT_LO;
            PH_BIT_LO:  if (phase_end_i) phase_d = PH_BIT_GAP;
            PH_BIT_GAP: if (phase_end_i) phase_d = last_bit ? PH_STOP : PH_BIT_SET;
            PH_STOP:    if (phase_end_i) phase_d = PH_IDLE;
            default:                     phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Bit index, cleared at acceptance and stepped after each bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                     bit_idx_q <= '0;
        else if (accept_o)              bit_idx_q <= '0;
        else if (advance_o && !last_bit) bit_idx_q <= bit_idx_q + IDX_W'(1);
    end

    assign phase_o   = phase_q;
    assign busy_o    = (phase_q != PH_IDLE);
    assign accept_o  = start_i && (phase_q == PH_IDLE);
    assign sample_o  = phase_end_i && (phase_q == PH_BIT_LO);
    assign advance_o = phase_end_i && (phase_q == PH_BIT_GAP);
    assign finish_o  = phase_end_i && (phase_q == PH_STOP);
endmodule

// File: rtl/cst_line_drive.sv
// Decodes the serial clock and data output levels from the current phase.
// Assumes: phase_i comes straight from a register, so the decode is a
// shallow function of flop outputs.
module cst_line_drive
    import cst_pkg::*;
(
    input  phase_e phase_i,
    input  logic   tx_bit_i,
    output logic   ser_clk_o,
    output logic   ser_dout_o
);
    // Map each phase to its pair of line levels.
    always_comb begin
        ser_clk_o  = 1'b1;
        ser_dout_o = 1'b1;
        unique case (phase_i)
            PH_IDLE:    begin ser_clk_o = 1'b1; ser_dout_o = 1'b1;     end
            PH_STA_A:   begin ser_clk_o = 1'b1; ser_dout_o = 1'b0;     end
            PH_STA_B:   begin ser_clk_o = 1'b0; ser_dout_o = 1'b0;     end
            PH_BIT_SET: begin ser_clk_o = 1'b0; ser_dout_o = tx_bit_i; end
            PH_BIT_HI:  begin ser_clk_o = 1'b1; ser_dout_o = tx_bit_i; end
            PH_BIT_LO:  begin ser_clk_o = 1'b0; ser_dout_o = tx_bit_i; end
            PH_BIT_GAP: begin ser_clk_o = 1'b0; ser_dout_o = tx_bit_i; end
            PH_STOP:    begin ser_clk_o = 1'b1; ser_dout_o = 1'b0;     end
            default:    begin ser_clk_o = 1'b1; ser_dout_o = 1'b1;     end
        endcase
    end
endmodule

// File: rtl/cst_shift_path.sv
// Data path: shifts the command out MSB first and shifts the reply in on
// the LSB side. It then builds the reported status with the command's page
// bits on top.
// Assumes: the strobes are single-cycle and come from the sequencer.
module cst_shift_path #(
    parameter int WORD_W = 32,
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [WORD_W-1:0] cmd_i,
    input  logic              advance_i,
    input  logic              sample_i,
    input  logic              finish_i,
    input  logic              din_i,
    output logic              tx_bit_o,
    output logic [WORD_W-1:0] status_o,
    output logic              done_o
);
    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_q;
    logic [PAGE_W-1:0] page_q;
    logic [WORD_W-1:0] status_q;
    logic              done_q;

    // Command shifter: load at acceptance, move to the next bit after each gap.
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_q <= '0;
        else if (accept_i)  tx_q <= cmd_i;
        else if (advance_i) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
    end

    // Page bits of the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n)        page_q <= '0;
        else if (accept_i) page_q <= cmd_i[WORD_W-1 -: PAGE_W];
    end

    // Reply shifter: enter each sampled bit on the LSB side.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_q <= '0;
        else if (accept_i) rx_q <= '0;
        else if (sample_i) rx_q <= {rx_q[WORD_W-2:0], din_i};
    end

    // Reported status, written only when a transaction completes.
    always_ff @(posedge clk) begin
        if (!rst_n)        status_q <= '0;
        else if (finish_i) status_q <= {page_q, rx_q[WORD_W-PAGE_W-1:0]};
    end

    // Completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= finish_i;
    end

    assign tx_bit_o = tx_q[WORD_W-1];
    assign status_o = status_q;
    assign done_o   = done_q;
endmodule

// File: rtl/cmdstat_serial_master.sv
// Top of the bit-serial command/status transceiver. Connects the sequencer,
// phase timer, input synchronizer, data path and line decode.
// Assumes: the far-side controller updates its output while the serial
// clock is low, and holds it for at least three system clocks before
// the end of a bit's third phase.
module cmdstat_serial_master
    import cst_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int PAGE_W      = 2,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] cmd_i,
    input  logic [CNT_W-1:0]  unit_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] status_o,
    output logic              ser_clk_o,
    output logic              ser_dout_o,
    input  logic              ser_din_i
);
    phase_e phase;
    logic   busy, accept, sample, advance, finish, phase_end;
    logic   din_sync, tx_bit;

    cst_sequencer #(.WORD_W(WORD_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_end_i(phase_end),
        .phase_o(phase), .busy_o(busy), .accept_o(accept),
        .sample_o(sample), .advance_o(advance), .finish_o(finish)
    );

    cst_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .load_i(accept), .unit_i(unit_i),
        .run_i(busy), .phase_end_o(phase_end)
    );

    cst_sync2 #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .d_i(ser_din_i), .q_o(din_sync)
    );

    cst_shift_path #(.WORD_W(WORD_W), .PAGE_W(PAGE_W)) i_path (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .cmd_i(cmd_i),
        .advance_i(advance), .sample_i(sample), .finish_i(finish),
        .din_i(din_sync), .tx_bit_o(tx_bit), .status_o(status_o), .done_o(done_o)
    );

    cst_line_drive i_line (
        .phase_i(phase), .tx_bit_i(tx_bit),
        .ser_clk_o(ser_clk_o), .ser_dout_o(ser_dout_o)
    );

    assign busy_o = busy;
endmodule

// File: rtl/cst_checker.sv
// Protocol checker for cmdstat_serial_master. It is bound to the top
// module and observes only its ports.
// Assumes: reset is held for at least one clock before the first transaction.
module cst_checker #(
    parameter int WORD_W = 32,
    parameter int PAGE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [WORD_W-1:0] cmd_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [WORD_W-1:0] status_o,
    input logic              ser_clk_o,
    input logic              ser_dout_o
);
    localparam int EC_W = $clog2(WORD_W + 2) + 1;

    logic [EC_W-1:0]   rise_cnt_q;
    logic              clk_prev_q;
    logic [PAGE_W-1:0] page_q;

    // Count rising serial clock edges within a transaction.
    always_ff @(posedge clk) begin
        if (!rst_n)                                rise_cnt_q <= '0;
        else if (start_i && !busy_o)               rise_cnt_q <= '0;
        else if (busy_o && ser_clk_o && !clk_prev_q) rise_cnt_q <= rise_cnt_q + EC_W'(1);
    end

    // Previous serial clock level, and page bits of the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_prev_q <= 1'b1;
            page_q     <= '0;
        end else begin
            clk_prev_q <= ser_clk_o;
            if (start_i && !busy_o) page_q <= cmd_i[WORD_W-1 -: PAGE_W];
        end
    end

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ser_clk_o && ser_dout_o)); // R1
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R2
    AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rise_cnt_q == EC_W'(WORD_W + 1))); // R4
    AST_PAGE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (status_o[WORD_W-1 -: PAGE_W] == page_q)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R8
    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(status_o)); // R8
endmodule

bind cmdstat_serial_master cst_checker #(.WORD_W(WORD_W), .PAGE_W(PAGE_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
    .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
    .ser_clk_o(ser_clk_o), .ser_dout_o(ser_dout_o)
);

// File: tb/test_cmdstat_serial_master.sv
// Cycle-by-cycle reference bench for cmdstat_serial_master.
module test_cmdstat_serial_master;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 100000;

    typedef struct {
        logic        sck;
        logic        sdo;
        logic        busy;
        logic        done;
        logic        din;
        logic [31:0] stat;
        string       tag;
    } ent_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] cmd_i = '0;
    logic [15:0] unit_i = 16'd1;
    logic        busy_o, done_o, ser_clk_o, ser_dout_o;
    logic        ser_din_i = 1'b1;
    logic [31:0] status_o;

    ent_t        q[$];
    logic [31:0] last_status = '0;
    int          compared = 0;
    int          mismatched = 0;
    int          cycles = 0;
    bit          ended = 0;

    cmdstat_serial_master i_cmdstat_serial_master (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
        .unit_i(unit_i), .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
        .ser_clk_o(ser_clk_o), .ser_dout_o(ser_dout_o), .ser_din_i(ser_din_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_eq(string tag, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic push_n(int n, logic sck, logic sdo, logic din, string tag);
        for (int k = 0; k < n; k++) begin
            ent_t e;
            e.sck = sck; e.sdo = sdo; e.busy = 1'b1; e.done = 1'b0;
            e.din = din; e.stat = last_status; e.tag = tag;
            q.push_back(e);
        end
    endtask

    // Build the expected trace of one transaction (R2..R8, R10).
    task automatic model_txn(logic [31:0] cmd, logic [31:0] resp, int unit, string tag);
        int   w;
        ent_t e;
        w = (unit == 0) ? 1 : unit;
        push_n(w, 1'b1, 1'b0, 1'b1, {tag, " R3 start-a"});
        push_n(w, 1'b0, 1'b0, 1'b1, {tag, " R3 start-b"});
        for (int i = 0; i < 32; i++) begin
            push_n(w, 1'b0, cmd[31-i], resp[31-i], {tag, " R4 set"});
            push_n(w, 1'b1, cmd[31-i], resp[31-i], {tag, " R4 high"});
            push_n(w, 1'b0, cmd[31-i], resp[31-i], {tag, " R4 low"});
            push_n(w, 1'b0, cmd[31-i], resp[31-i], {tag, " R4 gap"});
        end
        push_n(w, 1'b1, 1'b0, 1'b1, {tag, " R6 stop"});
        e.sck = 1'b1; e.sdo = 1'b1; e.busy = 1'b0; e.done = 1'b1; e.din = 1'b1;
        e.stat = {cmd[31:30], resp[29:0]};
        e.tag = {tag, " R5 R7 R8 done"};
        q.push_back(e);
    endtask

    // Per-cycle comparison against the model, and serial input drive.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            ent_t e;
            e = q.pop_front();
            if (e.done) last_status = e.stat;
            check_eq(e.tag, "ser_clk", {31'd0, ser_clk_o}, {31'd0, e.sck});
            check_eq(e.tag, "ser_dout", {31'd0, ser_dout_o}, {31'd0, e.sdo});
            check_eq({e.tag, " R2"}, "busy", {31'd0, busy_o}, {31'd0, e.busy});
            check_eq({e.tag, " R8"}, "done", {31'd0, done_o}, {31'd0, e.done});
            check_eq({e.tag, " R8"}, "status", status_o, last_status);
            ser_din_i = e.din;
        end else begin
            check_eq("R1 idle", "ser_clk", {31'd0, ser_clk_o}, 32'd1);
            check_eq("R1 idle", "ser_dout", {31'd0, ser_dout_o}, 32'd1);
            check_eq("R1 idle", "busy", {31'd0, busy_o}, 32'd0);
            check_eq("R8 idle", "done", {31'd0, done_o}, 32'd0);
            check_eq("R1 R8 idle", "status", status_o, last_status);
            ser_din_i = 1'b1;
        end
    end

    task automatic launch(logic [31:0] cmd, logic [31:0] resp, int unit, string tag);
        @(negedge clk); #1;
        cmd_i = cmd; unit_i = 16'(unit); start_i = 1'b1;
        model_txn(cmd, resp, unit, tag);
        @(negedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() > 0) begin
            @(negedge clk); #2;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_LIMIT && !ended) begin
            ended = 1;
            mismatched++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1 R11: reset state
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R4 R5 R7: mixed pattern, phase length 2
        launch(32'hA5C3_1E0F, 32'h3CF0_5A96, 2, "T1");
        wait_idle();

        // R7: page bits 01 replace captured 11, phase length 3
        launch(32'h4000_0001, 32'hFFFF_FFFF, 3, "T2");
        wait_idle();

        // R10: phase length 0 acts as 1; page 11 over captured 00
        launch(32'hFFFF_FFFE, 32'h0000_0001, 0, "T3 R10");
        wait_idle();

        // R9: start pulse and input changes while busy are ignored
        launch(32'h1234_5678, 32'h8765_4321, 1, "T4 R9");
        repeat (20) @(negedge clk);
        #1 start_i = 1'b1; cmd_i = 32'hFFFF_0000; unit_i = 16'd5;
        @(negedge clk); #1 start_i = 1'b0;
        repeat (10) @(negedge clk);
        #1 cmd_i = 32'h0; unit_i = 16'd7;
        wait_idle();
        repeat (2) @(negedge clk);

        // R11: reset in mid-transaction aborts to idle and clears status
        launch(32'h0F0F_F0F0, 32'hAAAA_5555, 2, "T5 R11");
        repeat (50) @(negedge clk);
        #1 rst_n = 1'b0;
        q.delete();
        last_status = '0;
        repeat (2) @(negedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2: a transaction after reset still runs in full
        launch(32'hC000_0000, 32'h5555_AAAA, 2, "T6 R2");
        wait_idle();
        repeat (3) @(negedge clk);

        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule